// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Datapath

This block is the data side of a 32-bit multicycle processor in which every movement of a word between units crosses one shared bus. An external sequencer supplies a set of control points each cycle. It enables exactly one bus source at most: the register file, the immediate generator, the ALU or memory. It can also raise the load enables of the instruction register, the two operand latches and the memory address register. Any number of these can capture the bus value on the same clock edge.

The register file has 32 general entries and keeps the program counter as one extra entry. A single select input addresses the source, second source or destination field of the held instruction, the PC, or the link register. The ALU always takes its operands from latches A and B. It reports whether they are equal, which the sequencer uses to decide branches. Memory sits outside the block. The block presents the address from the address register and the bus value as write data, and passes the memory's busy flag back to the sequencer.

Top module: `bus_datapath`

## Requirements
- R1: The bus carries the register file read value when en_reg_i is high, the immediate when en_imm_i is high, the ALU result when en_alu_i is high, and mem_rdata_i when en_mem_i is high. With no enable it carries zero. At most one enable is high per cycle, and bus_o shows the bus.
- R2: On a clock edge, the instruction register, latch A, latch B and the address register each load the bus value when their load enable is high, and hold otherwise. mem_addr_o shows the address register.
- R3: reg_sel_i codes: 0 selects instruction bits [19:15], 1 bits [24:20], 2 bits [11:7], 3 the PC (entry 32), 4 register 1, and 5 to 7 register 0. With reg_wr_i high, the bus value is written into the selected entry on the clock edge.
- R4: Register 0 always reads zero, and writes to it are dropped.
- R5: imm_sel_i codes, all sign-extended from instruction bit 31. 0: bits [31:20]. 1: {[31:25],[11:7]}. 2: {[31],[7],[30:25],[11:8]}, counted in halfwords. 3: bits [31:12] followed by 12 zeros. 4: {[31],[19:12],[20],[30:21]}, counted in halfwords. 5 to 7: zero.
- R6: alu_op_i codes: 0 A+B, 1 A-B, 2 A shifted left by B[4:0], 3 signed A<B, 4 unsigned A<B, 5 A^B, 6 logical right shift, 7 arithmetic right shift, 8 A|B, 9 A&B, 10 A, 11 B, 12 A+4, 13 A-4, 14 A+(B<<1), 15 zero.
- R7: zero_o is high exactly when latches A and B hold equal values.
- R8: opcode_o presents the low 7 bits of the instruction register.
- R9: mem_wdata_o equals the bus. mem_we_o follows mem_wr_i. mem_req_o is high when en_mem_i or mem_wr_i is high. busy_o follows mem_busy_i.
- R10: While rst_ni is low, all register file entries (the PC included) and all latches are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_reg_i | input | 1 | Register file drives bus |
| en_imm_i | input | 1 | Immediate generator drives bus |
| en_alu_i | input | 1 | ALU drives bus |
| en_mem_i | input | 1 | Memory read data drives bus |
| ld_ir_i | input | 1 | Load instruction register |
| ld_a_i | input | 1 | Load operand latch A |
| ld_b_i | input | 1 | Load operand latch B |
| ld_ma_i | input | 1 | Load memory address register |
| reg_sel_i | input | 3 | Register file entry select |
| reg_wr_i | input | 1 | Write bus into selected entry |
| imm_sel_i | input | 3 | Immediate format select |
| alu_op_i | input | 4 | ALU operation |
| mem_wr_i | input | 1 | Memory write (1) or read (0) |
| mem_rdata_i | input | 32 | Read data from memory |
| mem_busy_i | input | 1 | Memory access in progress |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_req_o | output | 1 | Memory access request |
| bus_o | output | 32 | Shared bus value |
| opcode_o | output | 7 | Instruction opcode field |
| zero_o | output | 1 | Operands equal |
| busy_o | output | 1 | Memory busy status |

## Verification
The bench builds the block with its defaults: a 32-bit word and 32 general registers plus the PC. With these values the instruction field positions line up with the register selects, so the shift amounts and every sign-extension path can be reached. The bench memory holds 256 words of random data and raises busy for the first three cycles of each access. Random reads therefore seed the instruction register, the latches and the registers with arbitrary words, including instructions whose fields name register 0 and the link register. A directed fetch sequence runs before the random control words and exercises the PC entry, the destination field and the register 0 drop.

// File: rtl/bus_dp_pkg.sv
package bus_dp_pkg;
  typedef enum logic [2:0] {
    RSEL_RS1  = 3'd0,
    RSEL_RS2  = 3'd1,
    RSEL_RD   = 3'd2,
    RSEL_PC   = 3'd3,
    RSEL_LINK = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    IMM_I = 3'd0,
    IMM_S = 3'd1,
    IMM_B = 3'd2,
    IMM_U = 3'd3,
    IMM_J = 3'd4
  } imm_sel_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9,
    ALU_PA   = 4'd10,
    ALU_PB   = 4'd11,
    ALU_INC4 = 4'd12,
    ALU_DEC4 = 4'd13,
    ALU_JT   = 4'd14,
    ALU_NIL  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/bus_regfile.sv
module bus_regfile import bus_dp_pkg::*; #(
  parameter int XLEN    = 32,
  parameter int NUM_GPR = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      rs1_i,
  input  logic [4:0]      rs2_i,
  input  logic [4:0]      rd_i,
  input  logic [2:0]      sel_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  localparam int NENT  = NUM_GPR + 1;
  localparam int PC_IX = NUM_GPR;
  localparam int IW    = $clog2(NENT);

  logic [IW-1:0]   idx;
  logic [XLEN-1:0] ent [NENT];

  always_comb begin
    case (sel_i)
      RSEL_RS1:  idx = IW'(rs1_i);
      RSEL_RS2:  idx = IW'(rs2_i);
      RSEL_RD:   idx = IW'(rd_i);
      RSEL_PC:   idx = IW'(PC_IX);
      RSEL_LINK: idx = IW'(1);
      default:   idx = '0;
    endcase
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign ent[g] = '0;
    end else begin : g_flop
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    q <= '0;
        else if (wr_i && idx == IW'(g)) q <= wdata_i;
      end
      assign ent[g] = q;
    end
  end

  assign rdata_o = (32'(idx) < NENT) ? ent[idx] : '0;
endmodule

// File: rtl/bus_immgen.sv
module bus_immgen import bus_dp_pkg::*; (
  input  logic [31:7] ir_i,
  input  logic [2:0]  sel_i,
  output logic [31:0] imm_o
);
  logic s;
  assign s = ir_i[31];

  always_comb begin
    case (sel_i)
      IMM_I:   imm_o = {{20{s}}, ir_i[31:20]};
      IMM_S:   imm_o = {{20{s}}, ir_i[31:25], ir_i[11:7]};
      IMM_B:   imm_o = {{20{s}}, s, ir_i[7], ir_i[30:25], ir_i[11:8]};
      IMM_U:   imm_o = {ir_i[31:12], 12'b0};
      IMM_J:   imm_o = {{12{s}}, s, ir_i[19:12], ir_i[20], ir_i[30:21]};
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_alu.sv
module bus_alu import bus_dp_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [3:0]      op_i,
  output logic [XLEN-1:0] y_o,
  output logic            eq_o
);
  localparam int SHW = $clog2(XLEN);
  logic [SHW-1:0] sh;
  assign sh   = b_i[SHW-1:0];
  assign eq_o = (a_i == b_i);

  always_comb begin
    case (op_i)
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_SLL:  y_o = a_i << sh;
      ALU_SLT:  y_o = XLEN'($signed(a_i) < $signed(b_i));
      ALU_SLTU: y_o = XLEN'(a_i < b_i);
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_SRL:  y_o = a_i >> sh;
      ALU_SRA:  y_o = $unsigned($signed(a_i) >>> sh);
      ALU_OR:   y_o = a_i | b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_PA:   y_o = a_i;
      ALU_PB:   y_o = b_i;
      ALU_INC4: y_o = a_i + XLEN'(4);
      ALU_DEC4: y_o = a_i - XLEN'(4);
      ALU_JT:   y_o = a_i + (b_i << 1);
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath import bus_dp_pkg::*; #(
  parameter int XLEN    = 32,
  parameter int NUM_GPR = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_reg_i,
  input  logic            en_imm_i,
  input  logic            en_alu_i,
  input  logic            en_mem_i,
  input  logic            ld_ir_i,
  input  logic            ld_a_i,
  input  logic            ld_b_i,
  input  logic            ld_ma_i,
  input  logic [2:0]      reg_sel_i,
  input  logic            reg_wr_i,
  input  logic [2:0]      imm_sel_i,
  input  logic [3:0]      alu_op_i,
  input  logic            mem_wr_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_busy_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] bus_o,
  output logic [6:0]      opcode_o,
  output logic            zero_o,
  output logic            busy_o
);
  logic [31:0]     ir_q;
  logic [XLEN-1:0] a_q, b_q, ma_q;
  logic [XLEN-1:0] rf_rd, imm, alu_y, bus;

  bus_regfile #(.XLEN(XLEN), .NUM_GPR(NUM_GPR)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rs1_i   (ir_q[19:15]),
    .rs2_i   (ir_q[24:20]),
    .rd_i    (ir_q[11:7]),
    .sel_i   (reg_sel_i),
    .wr_i    (reg_wr_i),
    .wdata_i (bus),
    .rdata_o (rf_rd)
  );

  logic [31:0] imm32;
  bus_immgen u_imm (
    .ir_i  (ir_q[31:7]),
    .sel_i (imm_sel_i),
    .imm_o (imm32)
  );
  assign imm = XLEN'(imm32);

  bus_alu #(.XLEN(XLEN)) u_alu (
    .a_i  (a_q),
    .b_i  (b_q),
    .op_i (alu_op_i),
    .y_o  (alu_y),
    .eq_o (zero_o)
  );

  // AND-OR bus: one-hot enables, idle bus reads zero
  assign bus = ({XLEN{en_reg_i}} & rf_rd)
             | ({XLEN{en_imm_i}} & imm)
             | ({XLEN{en_alu_i}} & alu_y)
             | ({XLEN{en_mem_i}} & mem_rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir_i) ir_q <= 32'(bus);
      if (ld_a_i)  a_q  <= bus;
      if (ld_b_i)  b_q  <= bus;
      if (ld_ma_i) ma_q <= bus;
    end
  end

  assign bus_o       = bus;
  assign opcode_o    = ir_q[6:0];
  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus;
  assign mem_we_o    = mem_wr_i;
  assign mem_req_o   = en_mem_i | mem_wr_i;
  assign busy_o      = mem_busy_i;
endmodule

// File: rtl/bus_datapath_chk.sv
module bus_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_reg_i,
  input logic            en_imm_i,
  input logic            en_alu_i,
  input logic            en_mem_i,
  input logic            ld_ir_i,
  input logic            ld_a_i,
  input logic            ld_b_i,
  input logic            ld_ma_i,
  input logic [2:0]      reg_sel_i,
  input logic [XLEN-1:0] bus_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [6:0]      opcode_o,
  input logic            zero_o
);
  assert_one_driver_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({en_reg_i, en_imm_i, en_alu_i, en_mem_i}) <= 1);

  assert_ma_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ma_i |=> mem_addr_o == $past(bus_o));

  assert_x0_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_reg_i && reg_sel_i == 3'd5) |-> bus_o == '0);

  assert_eq_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_a_i && ld_b_i) |=> zero_o);

  assert_ir_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ir_i |=> $stable(opcode_o));
endmodule

bind bus_datapath bus_datapath_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_reg_i   (en_reg_i),
  .en_imm_i   (en_imm_i),
  .en_alu_i   (en_alu_i),
  .en_mem_i   (en_mem_i),
  .ld_ir_i    (ld_ir_i),
  .ld_a_i     (ld_a_i),
  .ld_b_i     (ld_b_i),
  .ld_ma_i    (ld_ma_i),
  .reg_sel_i  (reg_sel_i),
  .bus_o      (bus_o),
  .mem_addr_o (mem_addr_o),
  .opcode_o   (opcode_o),
  .zero_o     (zero_o)
);

// File: tb/bus_datapath_tb.sv
`timescale 1ns/1ps
module bus_datapath_tb;
  localparam int LAT = 3;

  typedef struct packed {
    logic       er, ei, ea, em;
    logic       lir, la, lb, lma;
    logic [2:0] rsel;
    logic       rwr;
    logic [2:0] isel;
    logic [3:0] aop;
    logic       mwr;
  } ctl_t;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  ctl_t c;
  logic [31:0] mem_rdata;
  logic        mem_busy;
  logic [31:0] mem_addr, mem_wdata, bus;
  logic        mem_we, mem_req, zero, busy;
  logic [6:0]  opcode;

  bus_datapath u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .en_reg_i(c.er), .en_imm_i(c.ei), .en_alu_i(c.ea), .en_mem_i(c.em),
    .ld_ir_i(c.lir), .ld_a_i(c.la), .ld_b_i(c.lb), .ld_ma_i(c.lma),
    .reg_sel_i(c.rsel), .reg_wr_i(c.rwr), .imm_sel_i(c.isel),
    .alu_op_i(c.aop), .mem_wr_i(c.mwr),
    .mem_rdata_i(mem_rdata), .mem_busy_i(mem_busy),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_req_o(mem_req), .bus_o(bus), .opcode_o(opcode), .zero_o(zero),
    .busy_o(busy)
  );

  // memory environment: busy for the first LAT cycles of a request
  logic [31:0] mem [256];
  int unsigned mcnt = 0;
  assign mem_busy  = mem_req && (mcnt < LAT);
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req && !mem_busy && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mcnt <= mem_req ? mcnt + 1 : 0;
  end

  // reference state
  logic [31:0] m_rf [33];
  logic [31:0] m_ir, m_a, m_b, m_ma;
  int vectors = 0, miscompares = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_idx(logic [2:0] s);
    case (s)
      3'd0: return int'(m_ir[19:15]);
      3'd1: return int'(m_ir[24:20]);
      3'd2: return int'(m_ir[11:7]);
      3'd3: return 32;
      3'd4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_imm(logic [2:0] s);
    logic [12:0] bo;
    logic [20:0] jo;
    bo = {m_ir[31], m_ir[7], m_ir[30:25], m_ir[11:8], 1'b0};
    jo = {m_ir[31], m_ir[19:12], m_ir[20], m_ir[30:21], 1'b0};
    case (s)
      3'd0: return $unsigned($signed(m_ir) >>> 20);
      3'd1: return ($unsigned($signed(m_ir) >>> 20) & ~32'h1f) | ((m_ir >> 7) & 32'h1f);
      3'd2: return $unsigned($signed({{19{bo[12]}}, bo}) >>> 1);
      3'd3: return m_ir & 32'hffff_f000;
      3'd4: return $unsigned($signed({{11{jo[20]}}, jo}) >>> 1);
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    int sh = int'(b % 32);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a << sh;
      4'd3:  return ($signed(a) < $signed(b)) ? 1 : 0;
      4'd4:  return (a < b) ? 1 : 0;
      4'd5:  return a ^ b;
      4'd6:  return a >> sh;
      4'd7:  return $unsigned($signed(a) >>> sh);
      4'd8:  return a | b;
      4'd9:  return a & b;
      4'd10: return a;
      4'd11: return b;
      4'd12: return a + 4;
      4'd13: return a - 4;
      4'd14: return a + 2 * b;
      default: return 0;
    endcase
  endfunction

  // drive at negedge, compare before the edge, then advance the model
  task automatic step(input ctl_t k);
    logic [31:0] eb;
    string tb;
    int ix;
    c = k;
    #1;
    ix = ref_idx(k.rsel);
    eb = 0; tb = "R1";
    if (k.er) begin eb = m_rf[ix]; tb = (ix == 0) ? "R4" : "R3"; end
    if (k.ei) begin eb = ref_imm(k.isel); tb = "R5"; end
    if (k.ea) begin eb = ref_alu(k.aop, m_a, m_b); tb = "R6"; end
    if (k.em) begin eb = mem[m_ma[9:2]]; tb = "R9"; end
    check(tb, bus, eb);
    check("R7", {31'b0, zero}, {31'b0, m_a == m_b});
    check("R8", {25'b0, opcode}, {25'b0, m_ir[6:0]});
    check("R2", mem_addr, m_ma);
    check("R9", {mem_wdata[31:3], mem_we, mem_req, busy},
                {eb[31:3], k.mwr, k.em | k.mwr, mem_busy});
    @(posedge clk);
    if (k.rwr && ix != 0) m_rf[ix] = eb;
    if (k.lir) m_ir = eb;
    if (k.la)  m_a  = eb;
    if (k.lb)  m_b  = eb;
    if (k.lma) m_ma = eb;
    @(negedge clk);
  endtask

  function automatic ctl_t idle();
    ctl_t k = '0;
    return k;
  endfunction

  task automatic fetch();
    ctl_t k;
    k = idle(); k.er = 1; k.rsel = 3'd3; k.lma = 1; k.la = 1; step(k);
    for (int i = 0; i <= LAT; i++) begin
      k = idle(); k.em = 1; k.lir = 1; step(k);
    end
    k = idle(); k.ea = 1; k.aop = 4'd12; k.rwr = 1; k.rsel = 3'd3; step(k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    ctl_t k;
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    mem[0] = 32'hff30_0293;   // imm -13, rd = 5
    mem[1] = 32'h1230_0013;   // rd = 0
    for (int i = 0; i < 33; i++) m_rf[i] = 0;
    m_ir = 0; m_a = 0; m_b = 0; m_ma = 0;
    c = idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10: reset state
    c = idle(); c.er = 1; c.rsel = 3'd3; #1;
    check("R10", bus, 0);
    check("R10", mem_addr, 0);
    check("R10", {25'b0, opcode}, 0);
    check("R10", {31'b0, zero}, 1);
    @(negedge clk);

    // R3/R5/R6: fetch, load I immediate, write rd, read back
    fetch();
    k = idle(); k.er = 1; k.rsel = 3'd3; step(k);               // PC now 4
    k = idle(); k.ei = 1; k.isel = 3'd0; k.lb = 1; step(k);
    k = idle(); k.ea = 1; k.aop = 4'd11; k.rwr = 1; k.rsel = 3'd2; step(k);
    k = idle(); k.er = 1; k.rsel = 3'd2; step(k);               // expect fffffff3

    // R4: write to register 0 through the rd field, then read both ways
    fetch();
    k = idle(); k.ei = 1; k.isel = 3'd0; k.rwr = 1; k.rsel = 3'd2; step(k);
    k = idle(); k.er = 1; k.rsel = 3'd2; step(k);
    k = idle(); k.er = 1; k.rsel = 3'd5; step(k);

    // random legal control words
    for (int n = 0; n < 4000; n++) begin
      int d;
      k = ctl_t'($urandom);
      d = int'($urandom % 5);
      k.er = (d == 1); k.ei = (d == 2); k.ea = (d == 3); k.em = (d == 4);
      k.mwr = (($urandom % 8) == 0);
      step(k);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule